// File: doc/BRIEF.md
# Frame Relay HDLC Receiver

This block takes a serial line, one bit per cycle in which a bit enable is high, and recovers flag-delimited HDLC frames from it. It removes the zero bits that the sender stuffed in after runs of five ones. It checks a 16-bit or 32-bit frame check sequence and strips those octets from the data it passes on. It also reads the frame relay address field at the head of each frame. The address may be two, three or four octets long, and the block puts together the connection identifier that the field carries.

The output is a byte stream. A strobe marks each byte, and a start marker sits on the first byte of a frame. A separate end strobe follows the last byte. The end strobe carries the frame status: good or bad, and aborted or not. In the same cycle it carries the decoded identifier and a flag that says whether the frame arrived on the management channel. A configuration input picks identifier 0 or identifier 1023 as the management channel. In transparent mode the block skips address classification entirely. It then reports every frame with a zero identifier and no management flag. An external lookup maps the raw identifier to a connection.

Top module: `fr_hdlc_rx`

## Requirements
- R1: A frame opens after the flag 01111110 and closes at the next flag. Flags that follow each other with no whole octet between them produce no output. Each closed frame that holds at least one octet produces exactly one end strobe.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted. The remaining bits are packed into octets least significant bit first.
- R3: When cfg_fcs32 is 0, the last 2 octets are checked with the reflected CRC-CCITT (polynomial 0x8408, preset all ones, good residue 0xF0B8). When it is 1, the last 4 octets are checked with the reflected CRC-32 (0xEDB88320, preset all ones, good residue 0xDEBB20E3). These octets never appear on out_data, and out_good is 1 only when the residue matches.
- R4: Address octets continue while bit 0 is 0 and end on the octet where bit 0 is 1. The identifier is built from bits 7:2 of octet 1, then bits 7:4 of octet 2, then bits 7:1 of octets 3 and 4. Each new group is shifted in below the earlier bits. The identifier is shown on out_dlci with the end strobe.
- R5: If cfg_mgmt_hi is 0, out_mgmt is set at the end strobe of a frame whose valid identifier is 0. If cfg_mgmt_hi is 1, the identifier must be 1023 instead.
- R6: When cfg_transparent is 1, no address decoding takes place. out_dlci and out_mgmt stay 0. A frame is good when it is aligned, its FCS matches, and it holds more octets than the FCS length.
- R7: Seven consecutive 1s inside a frame abort it. The block gives an end strobe with out_abort=1 and out_good=0, then ignores the line until the next flag.
- R8: A frame is reported bad if its closing flag is not on an octet boundary. It is also bad if, in classify mode, its address starts with bit 0 set on octet 1, runs past 4 octets, or leaves fewer octets than the address plus the FCS.
- R9: After reset, out_valid, out_sof, out_eof, out_good, out_abort, out_mgmt and out_dlci are all 0.
- R10: out_sof is 1 only on the first data byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies bit_in in this cycle |
| bit_in | input | 1 | Serial line bit |
| cfg_fcs32 | input | 1 | 1: 32-bit FCS, 0: 16-bit FCS |
| cfg_mgmt_hi | input | 1 | Management identifier: 1 selects 1023, 0 selects 0 |
| cfg_transparent | input | 1 | 1: no address classification |
| out_valid | output | 1 | out_data holds a frame byte |
| out_data | output | 8 | Frame byte, FCS removed |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | End-of-frame strobe, never with out_valid |
| out_good | output | 1 | With out_eof: frame passed every check |
| out_abort | output | 1 | With out_eof: frame was aborted |
| out_dlci | output | 24 | With out_eof: decoded identifier |
| out_mgmt | output | 1 | With out_eof: management-channel frame |

## Verification
The assertions assume that the three configuration inputs stay constant from the opening flag to the end strobe of a frame. They also assume that reset is applied before the first bit arrives. The stimulus respects both assumptions. It changes configuration only while the line is idle between frames, with bit_en low. It drives one bit on every other cycle, and it always opens a frame with a complete flag, so that any abort it produces comes from a deliberate run of ones.

// File: rtl/fr_rx_pkg.sv
package fr_rx_pkg;
  // line codes
  localparam logic [7:0] FLAG_PAT   = 8'h7E;
  localparam int         STUFF_RUN  = 5;
  localparam int         FLAG_RUN   = 6;
  localparam int         RUN_MAX    = 7;
  localparam int         RUN_W      = $clog2(RUN_MAX + 1);

  // address field geometry
  localparam int OCT1_BITS    = 6;
  localparam int OCT2_BITS    = 4;
  localparam int EXT_BITS     = 7;
  localparam int MAX_ADDR_OCT = 4;
  localparam int ID_W         = OCT1_BITS + OCT2_BITS + (MAX_ADDR_OCT - 2) * EXT_BITS;
  localparam int IDX_W        = $clog2(MAX_ADDR_OCT + 1);

  // management identifiers
  localparam int MGMT_LO = 0;
  localparam int MGMT_HI = 1023;

  // frame check sequences (reflected register, LSB first)
  localparam int          FCS16_OCT = 2;
  localparam int          FCS32_OCT = 4;
  localparam logic [15:0] POLY16    = 16'h8408;
  localparam logic [15:0] RES16     = 16'hF0B8;
  localparam logic [31:0] POLY32    = 32'hEDB88320;
  localparam logic [31:0] RES32     = 32'hDEBB20E3;
endpackage

// File: rtl/fr_bit_deframer.sv
module fr_bit_deframer
  import fr_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       flag_stb,
  output logic       flag_aligned,
  output logic       abort_stb
);
  localparam logic [RUN_W-1:0] STUFF_N = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] FLAG_N  = RUN_W'(FLAG_RUN);
  localparam logic [RUN_W-1:0] MAX_N   = RUN_W'(RUN_MAX);

  logic             hunting;
  logic [RUN_W-1:0] ones;
  logic [6:0]       sh;
  logic [2:0]       bcnt;
  logic             take;

  // a bit is frame data unless it is a stuffed zero, a flag end or hunting
  always_comb begin
    take = 1'b0;
    if (!hunting) begin
      if (bit_in) take = (ones < FLAG_N);
      else        take = (ones != STUFF_N) && (ones != FLAG_N);
    end
  end

  always_ff @(posedge clk) begin
    byte_stb  <= 1'b0;
    flag_stb  <= 1'b0;
    abort_stb <= 1'b0;
    if (rst) begin
      hunting      <= 1'b1;
      ones         <= '0;
      sh           <= '0;
      bcnt         <= '0;
      byte_data    <= '0;
      flag_aligned <= 1'b0;
    end else if (bit_en) begin
      if (bit_in) begin
        if (ones != MAX_N) ones <= ones + 1'b1;
        if (ones == FLAG_N) begin
          abort_stb <= !hunting;
          hunting   <= 1'b1;
          bcnt      <= '0;
        end
      end else begin
        ones <= '0;
        if (ones == FLAG_N) begin
          flag_stb     <= !hunting;
          flag_aligned <= (bcnt == 3'd7);
          hunting      <= 1'b0;
          bcnt         <= '0;
        end
      end
      if (take) begin
        sh <= {bit_in, sh[6:1]};
        if (bcnt == 3'd7) begin
          byte_stb  <= 1'b1;
          byte_data <= {bit_in, sh};
          bcnt      <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  a_r7_abort_enters_hunt: assert property (@(posedge clk) disable iff (rst)
    abort_stb |-> hunting);
  a_r1_flag_restarts_octet: assert property (@(posedge clk) disable iff (rst)
    flag_stb |-> (bcnt == '0 && !hunting));
endmodule

// File: rtl/fr_crc_lane.sv
module fr_crc_lane #(
  parameter int           W       = 16,
  parameter logic [W-1:0] POLY    = '0,
  parameter logic [W-1:0] RESIDUE = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] data,
  output logic       ok
);
  logic [W-1:0] crc;

  function automatic logic [W-1:0] step8(input logic [W-1:0] c, input logic [7:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr)  crc <= '1;
    else if (upd)    crc <= step8(crc, data);
  end

  assign ok = (crc == RESIDUE);
endmodule

// File: rtl/fr_addr_parse.sv
module fr_addr_parse
  import fr_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            upd,
  input  logic [7:0]      data,
  output logic [ID_W-1:0] id,
  output logic            done,
  output logic            err,
  output logic [2:0]      len
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ADDR_OCT - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx  <= '0;
      id   <= '0;
      done <= 1'b0;
      err  <= 1'b0;
      len  <= '0;
    end else if (upd && !done && !err) begin
      idx <= idx + 1'b1;
      case (idx)
        IDX_W'(0): begin
          id <= ID_W'(data[7:8-OCT1_BITS]);
          if (data[0]) err <= 1'b1;
        end
        IDX_W'(1): begin
          id <= {id[ID_W-OCT2_BITS-1:0], data[7:8-OCT2_BITS]};
          if (data[0]) begin
            done <= 1'b1;
            len  <= 3'd2;
          end
        end
        default: begin
          id <= {id[ID_W-EXT_BITS-1:0], data[7:1]};
          if (data[0]) begin
            done <= 1'b1;
            len  <= 3'(idx + 1'b1);
          end else if (idx == LAST_IDX) begin
            err <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r4_done_excludes_err: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  a_r4_len_in_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (len >= 3'd2 && len <= 3'(MAX_ADDR_OCT)));
endmodule

// File: rtl/fr_hdlc_rx.sv
module fr_hdlc_rx
  import fr_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic            cfg_fcs32,
  input  logic            cfg_mgmt_hi,
  input  logic            cfg_transparent,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_sof,
  output logic            out_eof,
  output logic            out_good,
  output logic            out_abort,
  output logic [ID_W-1:0] out_dlci,
  output logic            out_mgmt
);
  localparam int HOLD_D = FCS32_OCT;

  logic            byte_stb, flag_stb, flag_aligned, abort_stb;
  logic [7:0]      byte_data;
  logic            frame_end;
  logic            ok16, ok32;
  logic [ID_W-1:0] a_id;
  logic            a_done, a_err;
  logic [2:0]      a_len;

  fr_bit_deframer u_deframer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .flag_stb(flag_stb), .flag_aligned(flag_aligned), .abort_stb(abort_stb)
  );

  assign frame_end = flag_stb | abort_stb;

  fr_crc_lane #(.W(16), .POLY(POLY16), .RESIDUE(RES16)) u_crc16 (
    .clk(clk), .rst(rst), .clr(frame_end), .upd(byte_stb), .data(byte_data), .ok(ok16)
  );

  fr_crc_lane #(.W(32), .POLY(POLY32), .RESIDUE(RES32)) u_crc32 (
    .clk(clk), .rst(rst), .clr(frame_end), .upd(byte_stb), .data(byte_data), .ok(ok32)
  );

  fr_addr_parse u_addr (
    .clk(clk), .rst(rst), .clr(frame_end), .upd(byte_stb), .data(byte_data),
    .id(a_id), .done(a_done), .err(a_err), .len(a_len)
  );

  logic [CNT_W-1:0] count, fcs_len;
  logic [7:0]       hold [HOLD_D];
  logic             fcs_ok, addr_ok, good_now, mgmt_hit;
  logic [ID_W-1:0]  mgmt_id;

  always_comb begin
    fcs_len  = cfg_fcs32 ? CNT_W'(FCS32_OCT) : CNT_W'(FCS16_OCT);
    fcs_ok   = cfg_fcs32 ? ok32 : ok16;
    addr_ok  = a_done && !a_err && (count >= CNT_W'(a_len) + fcs_len);
    mgmt_id  = cfg_mgmt_hi ? ID_W'(MGMT_HI) : ID_W'(MGMT_LO);
    mgmt_hit = addr_ok && (a_id == mgmt_id);
    if (cfg_transparent) good_now = flag_aligned && fcs_ok && (count > fcs_len);
    else                 good_now = flag_aligned && fcs_ok && addr_ok;
  end

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    out_sof   <= 1'b0;
    out_eof   <= 1'b0;
    out_good  <= 1'b0;
    out_abort <= 1'b0;
    out_mgmt  <= 1'b0;
    out_dlci  <= '0;
    if (rst) begin
      count    <= '0;
      out_data <= '0;
      for (int i = 0; i < HOLD_D; i++) hold[i] <= '0;
    end else begin
      if (byte_stb) begin
        if (count != '1) count <= count + 1'b1;
        hold[0] <= byte_data;
        for (int i = 1; i < HOLD_D; i++) hold[i] <= hold[i-1];
        if (count >= fcs_len) begin
          out_valid <= 1'b1;
          out_data  <= cfg_fcs32 ? hold[FCS32_OCT-1] : hold[FCS16_OCT-1];
          out_sof   <= (count == fcs_len);
        end
      end
      if (frame_end) begin
        count <= '0;
        if (count != '0) begin
          out_eof <= 1'b1;
          if (abort_stb) begin
            out_abort <= 1'b1;
          end else begin
            out_good <= good_now;
            if (!cfg_transparent && addr_ok) begin
              out_dlci <= a_id;
              out_mgmt <= mgmt_hit;
            end
          end
        end
      end
    end
  end

  a_r10_sof_on_byte: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  a_r1_eof_apart_from_byte: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_eof));
  a_r7_abort_is_bad: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> (out_eof && !out_good && !out_mgmt));
  a_r3_good_only_at_end: assert property (@(posedge clk) disable iff (rst)
    out_good |-> out_eof);
  a_r5_mgmt_id_value: assert property (@(posedge clk) disable iff (rst)
    out_mgmt |-> (out_dlci == ID_W'(MGMT_LO) || out_dlci == ID_W'(MGMT_HI)));
  a_r6_transparent_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_eof && $past(cfg_transparent)) |-> (!out_mgmt && out_dlci == '0));
endmodule

// File: tb/test_fr_hdlc_rx.sv
module test_fr_hdlc_rx;
  import fr_rx_pkg::*;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, bit_in = 1'b1;
  logic cfg_fcs32 = 1'b0, cfg_mgmt_hi = 1'b0, cfg_transparent = 1'b0;
  logic            out_valid, out_sof, out_eof, out_good, out_abort, out_mgmt;
  logic [7:0]      out_data;
  logic [ID_W-1:0] out_dlci;

  always #10 clk = ~clk;

  fr_hdlc_rx i_fr_hdlc_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_fcs32(cfg_fcs32), .cfg_mgmt_hi(cfg_mgmt_hi), .cfg_transparent(cfg_transparent),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_good(out_good), .out_abort(out_abort), .out_dlci(out_dlci), .out_mgmt(out_mgmt)
  );

  typedef struct packed {
    logic [3:0]  len;
    logic [63:0] pay;
    logic        f32;
    logic        mhi;
    logic        tr;
    logic        good;
    logic        mg;
    logic [23:0] id;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd4, 64'h55AA0104,     1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'd16},
    '{4'd4, 64'h7EFFF1FC,     1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 24'd1023},
    '{4'd3, 64'h120100,       1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd0},
    '{4'd3, 64'h340100,       1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 24'd0},
    '{4'd2, 64'hF1FC,         1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'd1023},
    '{4'd4, 64'hC30B2004,     1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'd2309},
    '{4'd6, 64'h0F5A03FE1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'd32641},
    '{4'd3, 64'h990100,       1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'd0},
    '{4'd1, 64'h7E,           1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'd0},
    '{4'd6, 64'h01FEFEFE1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'd0},
    '{4'd3, 64'h332201,       1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'd0},
    '{4'd1, 64'h04,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'd0}
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // capture of the output stream
  logic [7:0]      cap_data [256];
  logic            cap_sof  [256];
  int              cap_n = 0, eof_n = 0;
  logic            last_good = 1'b0, last_abort = 1'b0, last_mgmt = 1'b0;
  logic [ID_W-1:0] last_dlci = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (cap_n < 256) begin
          cap_data[cap_n] <= out_data;
          cap_sof[cap_n]  <= out_sof;
        end
        cap_n <= cap_n + 1;
      end
      if (out_eof) begin
        eof_n      <= eof_n + 1;
        last_good  <= out_good;
        last_abort <= out_abort;
        last_mgmt  <= out_mgmt;
        last_dlci  <= out_dlci;
      end
    end
  end

  // line driver: one bit every other cycle
  int run1 = 0;
  logic [7:0] fb [16];

  task automatic raw(input logic b);
    @(posedge clk); #1;
    bit_in = b;
    bit_en = 1'b1;
    @(posedge clk); #1;
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) raw(FLAG_PAT[i]);
    run1 = 0;
  endtask

  task automatic dbit(input logic b);
    raw(b);
    if (b) begin
      run1++;
      if (run1 == 5) begin
        raw(1'b0);
        run1 = 0;
      end
    end else begin
      run1 = 0;
    end
  endtask

  task automatic dbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) dbit(v[i]);
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d, input bit f32);
    logic [31:0] r;
    logic        fbk;
    r = f32 ? c : (c & 32'h0000FFFF);
    for (int i = 0; i < 8; i++) begin
      fbk = r[0] ^ d[i];
      r = r >> 1;
      if (fbk) r = r ^ (f32 ? 32'hEDB88320 : 32'h00008408);
    end
    return r;
  endfunction

  task automatic send(input int n, input bit f32, input bit corrupt, input int extra);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < n; i++) c = crc_byte(c, fb[i], f32);
    c = ~c;
    send_flag();
    for (int i = 0; i < n; i++) dbyte((i == 0 && corrupt) ? (fb[i] ^ 8'h80) : fb[i]);
    for (int k = 0; k < (f32 ? 4 : 2); k++) dbyte(c[8*k +: 8]);
    for (int k = 0; k < extra; k++) dbit(k[0]);
    send_flag();
    send_flag();
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b0, e0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid after reset", out_valid, 0);
    chk("R9 out_eof after reset", out_eof, 0);
    chk("R9 out_good after reset", out_good, 0);
    chk("R9 out_dlci after reset", out_dlci, 0);
    chk("R9 out_mgmt after reset", out_mgmt, 0);

    // R1 back-to-back flags only
    b0 = cap_n; e0 = eof_n;
    for (int i = 0; i < 6; i++) send_flag();
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R1 no end strobe for flags only", eof_n - e0, 0);
    chk("R1 no bytes for flags only", cap_n - b0, 0);

    // table of frames
    for (int v = 0; v < NV; v++) begin
      cfg_fcs32       = VEC[v].f32;
      cfg_mgmt_hi     = VEC[v].mhi;
      cfg_transparent = VEC[v].tr;
      for (int i = 0; i < 16; i++) fb[i] = (i < 8) ? VEC[v].pay[8*i +: 8] : 8'h00;
      b0 = cap_n; e0 = eof_n;
      send(int'(VEC[v].len), VEC[v].f32, 1'b0, 0);
      @(negedge clk);
      chk("R1 one end strobe per frame", eof_n - e0, 1);
      if (VEC[v].tr)
        chk("R6 transparent good status", last_good, VEC[v].good);
      else if (!VEC[v].good)
        chk("R8 bad address or length", last_good, 0);
      else
        chk("R3 good status", last_good, 1);
      chk(VEC[v].tr ? "R6 transparent identifier" : "R4 identifier", last_dlci, VEC[v].id);
      chk(VEC[v].tr ? "R6 transparent mgmt flag" : "R5 mgmt flag", last_mgmt, VEC[v].mg);
      chk("R7 no abort on clean frame", last_abort, 0);
      chk("R3 FCS stripped byte count", cap_n - b0, int'(VEC[v].len));
      for (int i = 0; i < int'(VEC[v].len); i++) begin
        chk("R2 destuffed data byte", cap_data[b0 + i], fb[i]);
        chk("R10 start marker", cap_sof[b0 + i], (i == 0) ? 1 : 0);
      end
    end

    // R3 corrupted payload
    cfg_fcs32 = 1'b0; cfg_mgmt_hi = 1'b0; cfg_transparent = 1'b0;
    for (int i = 0; i < 4; i++) fb[i] = VEC[0].pay[8*i +: 8];
    e0 = eof_n;
    send(4, 1'b0, 1'b1, 0);
    @(negedge clk);
    chk("R3 corrupted frame end strobe", eof_n - e0, 1);
    chk("R3 corrupted frame is bad", last_good, 0);

    // R3 16-bit FCS frame checked as 32-bit
    cfg_fcs32 = 1'b1;
    e0 = eof_n;
    send(4, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk("R3 wrong FCS width is bad", last_good, 0);
    cfg_fcs32 = 1'b0;

    // R8 closing flag off the octet boundary
    e0 = eof_n;
    send(4, 1'b0, 1'b0, 3);
    @(negedge clk);
    chk("R8 misaligned end strobe", eof_n - e0, 1);
    chk("R8 misaligned frame is bad", last_good, 0);

    // R7 abort inside a frame
    e0 = eof_n;
    send_flag();
    dbyte(8'h04); dbyte(8'h01); dbyte(8'h33);
    for (int i = 0; i < 8; i++) raw(1'b1);
    run1 = 0;
    send_flag();
    send_flag();
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 abort end strobe", eof_n - e0, 1);
    chk("R7 abort marker", last_abort, 1);
    chk("R7 aborted frame not good", last_good, 0);

    // R1 frame after abort still decoded
    e0 = eof_n;
    send(4, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk("R1 frame after abort end strobe", eof_n - e0, 1);
    chk("R1 frame after abort good", last_good, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule